// File: doc/BRIEF.md
# Fiber Far-End Fault Signalling

This block handles far-end fault indication for a 100BASE-FX port at the level of serial code bits. On the transmit side it sits between the encoder's bit stream and the line. When the local optical receiver reports no signal, and the port is between frames, it replaces the idle bits with a repeating fault pattern. The pattern is a run of 84 ones closed by a single zero. During a frame the transmit stream passes through untouched.

On the receive side it watches the incoming bit stream for the same pattern from the link partner. When the pattern is seen it raises a status flag. The flag stays set while the pattern keeps arriving. It drops once three supervision windows pass with no valid pattern. A per-port disable bit turns off both sending and reporting. The block is instantiated only on the fiber-capable port.

Top module: `fx_fault_signal`

## Requirements
- R1: After a synchronous reset the status output `fault_seen` is 0, and the transmit pattern position is at its first bit.
- R2: While `sig_detect` is 0, `fef_disable` is 0 and `frame_active` is 0, `tx_bit_out` repeats a fixed 85-bit sequence. Bits 0 to 83 are 1 and bit 84 is 0, and bit 0 is sent in the first such cycle.
- R3: While `sig_detect` is 1, `tx_bit_out` equals `tx_bit_in`.
- R4: While `frame_active` is 1, `tx_bit_out` equals `tx_bit_in`, whatever `sig_detect` is.
- R5: If `frame_active` rises partway through a pattern, the pattern is dropped. The next idle cycle with the fault present sends bit 0 again, so 84 ones and then a zero follow.
- R6: While `fef_disable` is 1, `tx_bit_out` equals `tx_bit_in`, even with `sig_detect` at 0.
- R7: A 0 on `rx_bit` that comes directly after exactly 84 consecutive ones sets `fault_seen` at the next clock edge.
- R8: A 0 on `rx_bit` after a run of 83 ones, or after a run of 85 or more ones, does not set `fault_seen`.
- R9: After the last valid pattern, `fault_seen` stays 1 for exactly 3 x RX_WIN clock cycles, with RX_WIN = 128 by default. It is then 0.
- R10: A new valid pattern that arrives while `fault_seen` is 1 restarts the R9 hold time.
- R11: While `fef_disable` is 1, `fault_seen` is 0 from the next clock edge, and a valid pattern does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_bit_in | input | 1 | Transmit code bit from the encoder |
| frame_active | input | 1 | High while a frame is being transmitted |
| sig_detect | input | 1 | Local receive signal detect, 0 means no light |
| fef_disable | input | 1 | 1 turns off fault sending and reporting |
| tx_bit_out | output | 1 | Code bit sent to the line |
| rx_bit | input | 1 | Received code bit from the line |
| fault_seen | output | 1 | Far-end fault reported by the link partner |

## Verification
The bench sends runs of 83, 84 and 85 ones. A matcher that counts at least 84 ones instead of exactly 84 would flag the over-long run, and an off-by-one counter would flag the short one. It also aborts a transmit pattern mid-run with a frame. A generator that resumes instead of restarting would place its zero too early.

The hold time is sampled one cycle before and one cycle after it ends, so a window or miss counter that is off by one either drops the flag early or keeps it too long. The bench also checks that a second pattern restarts the hold time. Finally, it asserts the disable bit both before and after a fault is flagged, which catches a design that gates only one of the two directions.

// File: rtl/fef_pkg.sv
package fef_pkg;

    localparam int unsigned FEF_ONES_DEF = 84;
    localparam int unsigned FEF_WIN_DEF  = 128;
    localparam int unsigned FEF_MISS_DEF = 3;

    typedef enum logic [1:0] {
        TXM_PASS    = 2'd0,
        TXM_FRAME   = 2'd1,
        TXM_PATTERN = 2'd2
    } tx_mode_e;

    typedef struct packed {
        logic match;
        logic overlong;
    } rx_evt_t;

    function automatic tx_mode_e fef_pick_mode(input logic sd,
                                               input logic dis,
                                               input logic frame);
        if (frame)
            return TXM_FRAME;
        if (sd || dis)
            return TXM_PASS;
        return TXM_PATTERN;
    endfunction

endpackage

// File: rtl/fef_tx_gen.sv
module fef_tx_gen
    import fef_pkg::*;
#(
    parameter int unsigned ONES_LEN = FEF_ONES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_bit_in,
    input  logic frame_active,
    input  logic sig_detect,
    input  logic fef_disable,
    output logic tx_bit_out
);
    localparam int unsigned CW = $clog2(ONES_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(ONES_LEN);

    tx_mode_e        mode;
    logic [CW-1:0]   pos;

    always_comb mode = fef_pick_mode(sig_detect, fef_disable, frame_active);

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (mode != TXM_PATTERN)
            pos <= '0;
        else if (pos == LAST)
            pos <= '0;
        else
            pos <= pos + CW'(1);
    end

    always_comb begin
        case (mode)
            TXM_PATTERN: tx_bit_out = (pos != LAST);
            default:     tx_bit_out = tx_bit_in;
        endcase
    end

endmodule

// File: rtl/fef_rx_match.sv
module fef_rx_match
    import fef_pkg::*;
#(
    parameter int unsigned ONES_LEN = FEF_ONES_DEF
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    rx_bit,
    output rx_evt_t evt
);
    localparam int unsigned RW = $clog2(ONES_LEN + 2);
    localparam logic [RW-1:0] SAT  = RW'(ONES_LEN + 1);
    localparam logic [RW-1:0] GOAL = RW'(ONES_LEN);

    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)
            run <= '0;
        else if (rx_bit)
            run <= (run == SAT) ? run : run + RW'(1);
        else
            run <= '0;
    end

    always_comb begin
        evt.match    = !rx_bit && (run == GOAL);
        evt.overlong = (run == SAT);
    end

endmodule

// File: rtl/fef_hold.sv
module fef_hold
    import fef_pkg::*;
#(
    parameter int unsigned RX_WIN = FEF_WIN_DEF,
    parameter int unsigned MISSES = FEF_MISS_DEF
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fef_disable,
    input  rx_evt_t evt,
    output logic    fault_seen
);
    localparam int unsigned TW = $clog2(RX_WIN);
    localparam int unsigned MW = $clog2(MISSES + 1);
    localparam logic [TW-1:0] TEND = TW'(RX_WIN - 1);
    localparam logic [MW-1:0] MEND = MW'(MISSES - 1);

    logic [TW-1:0] timer;
    logic [MW-1:0] miss;
    logic          flag;
    logic          unused_ok;

    always_comb unused_ok = evt.overlong;

    always_ff @(posedge clk) begin
        if (rst || fef_disable) begin
            flag  <= 1'b0;
            timer <= '0;
            miss  <= '0;
        end else if (evt.match) begin
            flag  <= 1'b1;
            timer <= '0;
            miss  <= '0;
        end else if (timer == TEND) begin
            timer <= '0;
            if (flag) begin
                if (miss == MEND) begin
                    flag <= 1'b0;
                    miss <= '0;
                end else begin
                    miss <= miss + MW'(1);
                end
            end
        end else begin
            timer <= timer + TW'(1);
        end
    end

    assign fault_seen = flag;

endmodule

// File: rtl/fx_fault_signal.sv
module fx_fault_signal
    import fef_pkg::*;
#(
    parameter int unsigned ONES_LEN = FEF_ONES_DEF,
    parameter int unsigned RX_WIN   = FEF_WIN_DEF,
    parameter int unsigned MISSES   = FEF_MISS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_bit_in,
    input  logic frame_active,
    input  logic sig_detect,
    input  logic fef_disable,
    output logic tx_bit_out,
    input  logic rx_bit,
    output logic fault_seen
);
    rx_evt_t rx_evt;

    fef_tx_gen #(.ONES_LEN(ONES_LEN)) u_tx (
        .clk(clk), .rst(rst), .tx_bit_in(tx_bit_in),
        .frame_active(frame_active), .sig_detect(sig_detect),
        .fef_disable(fef_disable), .tx_bit_out(tx_bit_out)
    );

    fef_rx_match #(.ONES_LEN(ONES_LEN)) u_rx (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .evt(rx_evt)
    );

    fef_hold #(.RX_WIN(RX_WIN), .MISSES(MISSES)) u_hold (
        .clk(clk), .rst(rst), .fef_disable(fef_disable),
        .evt(rx_evt), .fault_seen(fault_seen)
    );

endmodule

// File: rtl/fx_fault_signal_chk.sv
module fx_fault_signal_chk #(
    parameter int unsigned ONES_LEN = 84
) (
    input logic clk,
    input logic rst,
    input logic tx_bit_in,
    input logic frame_active,
    input logic sig_detect,
    input logic fef_disable,
    input logic tx_bit_out,
    input logic rx_bit,
    input logic fault_seen
);
    logic        inject_idle;
    int unsigned ones_run;

    always_comb inject_idle = !sig_detect && !fef_disable && !frame_active;

    always_ff @(posedge clk) begin
        if (rst)
            ones_run <= 0;
        else if (inject_idle && tx_bit_out)
            ones_run <= ones_run + 1;
        else
            ones_run <= 0;
    end

    // R2
    pattern_zero_place_chk: assert property (@(posedge clk) disable iff (rst)
        (inject_idle && !tx_bit_out) |-> (ones_run == ONES_LEN));

    // R2
    pattern_run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        inject_idle |-> (ones_run <= ONES_LEN));

    // R4
    frame_pass_chk: assert property (@(posedge clk) disable iff (rst)
        frame_active |-> (tx_bit_out == tx_bit_in));

    // R3
    light_pass_chk: assert property (@(posedge clk) disable iff (rst)
        sig_detect |-> (tx_bit_out == tx_bit_in));

    // R6
    dis_tx_pass_chk: assert property (@(posedge clk) disable iff (rst)
        fef_disable |-> (tx_bit_out == tx_bit_in));

    // R11
    dis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fef_disable |=> !fault_seen);

    // R7
    set_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_seen) |-> (!$past(rx_bit) && !$past(fef_disable)));

endmodule

bind fx_fault_signal fx_fault_signal_chk #(.ONES_LEN(ONES_LEN)) u_chk (
    .clk(clk), .rst(rst), .tx_bit_in(tx_bit_in), .frame_active(frame_active),
    .sig_detect(sig_detect), .fef_disable(fef_disable),
    .tx_bit_out(tx_bit_out), .rx_bit(rx_bit), .fault_seen(fault_seen)
);

// File: tb/fx_fault_signal_tb.sv
module fx_fault_signal_tb;
    localparam int PER  = 10;
    localparam int ONES = 84;
    localparam int WIN  = 128;
    localparam int WD   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_bit_in = 1'b0, frame_active = 1'b0, sig_detect = 1'b1;
    logic fef_disable = 1'b0, rx_bit = 1'b1;
    logic tx_bit_out, fault_seen;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #(PER/2) clk = ~clk;

    fx_fault_signal u_dut (
        .clk(clk), .rst(rst), .tx_bit_in(tx_bit_in), .frame_active(frame_active),
        .sig_detect(sig_detect), .fef_disable(fef_disable),
        .tx_bit_out(tx_bit_out), .rx_bit(rx_bit), .fault_seen(fault_seen)
    );

    // {sig_detect, fef_disable, frame_active, tx_bit_in, expected tx_bit_out}
    localparam logic [4:0] VEC [10] = '{
        5'b1_0_0_0_0, 5'b1_0_0_1_1, 5'b0_0_0_0_1, 5'b0_0_0_0_1,
        5'b0_0_1_0_0, 5'b0_0_1_1_1, 5'b0_1_0_0_0, 5'b0_1_0_1_1,
        5'b1_1_1_0_0, 5'b0_0_0_1_1
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
    endtask

    task automatic rx_send(input int n_ones);
        rx_bit = 1'b0; step();
        for (int i = 0; i < n_ones; i++) begin rx_bit = 1'b1; step(); end
        rx_bit = 1'b0; step();
        rx_bit = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R1 reset state
        chk("R1 status after reset", fault_seen, 1'b0);
        sig_detect = 1'b0;
        #1;
        chk("R1 first bit is pattern bit 0", tx_bit_out, 1'b1);
        sig_detect = 1'b1;
        step();

        // vector table: R3 R4 R6 and start of R2
        for (int v = 0; v < 10; v++) begin
            {sig_detect, fef_disable, frame_active, tx_bit_in} = VEC[v][4:1];
            #1;
            chk("R3/R4/R6 vector", tx_bit_out, VEC[v][0]);
            step();
        end

        // R2 two full patterns, idle input held at 0
        sig_detect = 1'b1; fef_disable = 1'b0; frame_active = 1'b0; tx_bit_in = 1'b0;
        step();
        sig_detect = 1'b0;
        for (int k = 0; k < 2 * (ONES + 1); k++) begin
            #1;
            chk("R2 pattern bit", tx_bit_out, (k % (ONES + 1)) != ONES);
            step();
        end

        // R5 abort mid-pattern and restart
        for (int k = 0; k < 20; k++) step();
        frame_active = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tx_bit_in = k[0];
            #1;
            chk("R4 frame passes data", tx_bit_out, k[0]);
            step();
        end
        frame_active = 1'b0; tx_bit_in = 1'b0;
        for (int k = 0; k <= ONES; k++) begin
            #1;
            chk("R5 restart from bit 0", tx_bit_out, k != ONES);
            step();
        end

        // R6 disabled: no injection for a full pattern length
        fef_disable = 1'b1;
        for (int k = 0; k < ONES + 2; k++) begin
            #1;
            chk("R6 disable passes idle", tx_bit_out, 1'b0);
            step();
        end
        fef_disable = 1'b0; sig_detect = 1'b1;

        // R8 short and long runs
        do_reset();
        rx_send(ONES - 1);
        chk("R8 run of 83 ignored", fault_seen, 1'b0);
        rx_send(ONES + 1);
        chk("R8 run of 85 ignored", fault_seen, 1'b0);
        for (int k = 0; k < 200; k++) step();
        rx_bit = 1'b0; step(); rx_bit = 1'b1;
        chk("R8 overlong run ignored", fault_seen, 1'b0);

        // R7 exact pattern, R9 hold timing
        do_reset();
        rx_send(ONES);
        chk("R7 exact pattern sets status", fault_seen, 1'b1);
        for (int k = 0; k < 3 * WIN - 1; k++) step();
        chk("R9 still set at end of hold", fault_seen, 1'b1);
        step();
        chk("R9 cleared after hold", fault_seen, 1'b0);

        // R10 re-detect restarts hold
        do_reset();
        rx_send(ONES);
        for (int k = 0; k < 2 * WIN; k++) step();
        rx_send(ONES);
        chk("R10 second pattern keeps status", fault_seen, 1'b1);
        for (int k = 0; k < 2 * WIN; k++) step();
        chk("R10 hold restarted", fault_seen, 1'b1);
        for (int k = 0; k < WIN; k++) step();
        chk("R10 cleared after restarted hold", fault_seen, 1'b0);

        // R11 disable clears and blocks
        do_reset();
        rx_send(ONES);
        chk("R11 precondition set", fault_seen, 1'b1);
        fef_disable = 1'b1;
        step();
        chk("R11 disable clears status", fault_seen, 1'b0);
        rx_send(ONES);
        chk("R11 disable blocks pattern", fault_seen, 1'b0);
        fef_disable = 1'b0;
        step();
        chk("R11 stays clear after disable drops", fault_seen, 1'b0);

        // R1 reset clears a set status
        rx_send(ONES);
        rst = 1'b1; step(); rst = 1'b0;
        chk("R1 reset clears status", fault_seen, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule